// File: doc/BRIEF.md
# Eight-Pin Digital Port Controller with Selectable Pad Drive

This block runs one port of eight general-purpose pins on a small microcontroller register bus. Each pin has an output latch and a two-bit drive code. A separate analog-enable bit and a bypass bit can override the normal path. From this state the block makes four registered pad-control vectors: strong-high enable, strong-low enable, pull-up enable and input-buffer enable. It also takes in the levels sampled at the pads.

A read at the data offset does not return the latch. It returns the pad levels, after a two-flop synchronizer. Software that does a read-modify-write on the data offset therefore copies any externally forced low back into the latch. This can turn a pin that was only resistively high into a strong low. A pin with bypass set takes its output bit from a peripheral signal, and its drive code still decides how that bit reaches the pad.

Top module: `gpio_port_ctrl`

## Requirements
- R1: A bus write at offset 0 stores one latch bit per pin. With bypass clear, that bit is the output data seen by the drive decode. The pad outputs follow one cycle after the register updates.
- R2: A read at offset 0 returns each pad level through a two-flop synchronizer, not the latch value. `reg_rdata` is registered and valid in the cycle after the read strobe. A pad level that has been stable for two cycles before the strobe is returned.
- R3: Drive code 00 (resistive pull-up, strong low): an output bit of 0 enables only the strong-low driver, and a bit of 1 enables only the pull-up.
- R4: Drive code 01 (push-pull): an output bit of 1 enables only strong-high, and a bit of 0 enables only strong-low.
- R5: Drive code 10 (digital high-Z input): no driver and no pull-up is enabled, whatever the output bit.
- R6: Drive code 11 (open drain): an output bit of 0 enables only strong-low, and a bit of 1 leaves the pin with every driver and the pull-up off.
- R7: With a pin's analog-enable bit (offset 3) set, all drivers, the pull-up and the input buffer are off for that pin, whatever its drive code. A read at offset 0 returns 0 for that bit.
- R8: The input buffer enable of a pin is 1 whenever its analog-enable bit is 0.
- R9: With a pin's bypass bit (offset 4) set, its output bit is taken from `periph_out` instead of the latch. The drive code still applies.
- R10: After reset, the latch, analog and bypass registers read 0. The code-bit-0 register (offset 1) reads 0x00 and the code-bit-1 register (offset 2) reads 0xFF, so every pin is a high-Z digital input. The outputs are strong-high 0, strong-low 0, pull-up 0 and input enable 0xFF.
- R11: Strong-high and strong-low are never both enabled for the same pin in any cycle.
- R12: Offsets 1 to 4 read back the last value written to them. A pin's drive code is {offset 2 bit, offset 1 bit}. Offsets 5 to 7 read 0, and writes to them change no state.
- R13: A read-modify-write at offset 0 in code 00 stores 0 for any pin held low externally. That pin then stays strong-low after the external low is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Levels sampled at the pads |
| periph_out | input | 8 | Peripheral output bits used by bypassed pins |
| pad_drv_hi | output | 8 | Strong-high driver enables |
| pad_drv_lo | output | 8 | Strong-low driver enables |
| pad_pull_up | output | 8 | Pull-up enables |
| pad_in_en | output | 8 | Digital input buffer enables |

## Verification
The synchronizer check assumes reset is held for at least two clocks, so that the two-cycle history of `pad_in` is defined when checking starts. The bench holds reset for several cycles and drives `pad_in` from time zero. Stimulus changes pad and peripheral inputs only at falling edges. It waits two full cycles after any pad change before reading, so returned levels have always settled through both flops. Read and write strobes are never raised in the same cycle.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned OFF_DATA  = 0;
  localparam int unsigned OFF_MODE0 = 1;
  localparam int unsigned OFF_MODE1 = 2;
  localparam int unsigned OFF_ANA   = 3;
  localparam int unsigned OFF_BYP   = 4;

  typedef enum logic [1:0] {
    DRV_PULL_STRONG0 = 2'b00,
    DRV_PUSH_PULL    = 2'b01,
    DRV_HIZ_INPUT    = 2'b10,
    DRV_OPEN_DRAIN   = 2'b11
  } drv_code_e;
endpackage

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned ADDR_W   = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr,
  input  logic [NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0] data_q,
  output logic [NUM_PINS-1:0] mode0_q,
  output logic [NUM_PINS-1:0] mode1_q,
  output logic [NUM_PINS-1:0] ana_q,
  output logic [NUM_PINS-1:0] byp_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      mode0_q <= '0;
      mode1_q <= '1;
      ana_q   <= '0;
      byp_q   <= '0;
    end else if (wr) begin
      case (int'(addr))
        OFF_DATA:  data_q  <= wdata;
        OFF_MODE0: mode0_q <= wdata;
        OFF_MODE1: mode1_q <= wdata;
        OFF_ANA:   ana_q   <= wdata;
        OFF_BYP:   byp_q   <= wdata;
        default: ;
      endcase
    end
  end

  // R12
  mode_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && int'(addr) == OFF_MODE1) |=> (mode1_q == $past(wdata)));
endmodule

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pad,
  output logic [NUM_PINS-1:0] pad_sync
);
  logic [STAGES-1:0][NUM_PINS-1:0] stage_q;

  always_ff @(posedge clk) begin
    stage_q <= {stage_q[STAGES-2:0], pad};
  end

  assign pad_sync = stage_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      // R2
      sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
        pad_sync == $past(pad, 2));
    end
  endgenerate
endmodule

// File: rtl/gpio_drive_decode.sv
module gpio_drive_decode
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] data_q,
  input  logic [NUM_PINS-1:0] mode0_q,
  input  logic [NUM_PINS-1:0] mode1_q,
  input  logic [NUM_PINS-1:0] ana_q,
  input  logic [NUM_PINS-1:0] byp_q,
  input  logic [NUM_PINS-1:0] periph,
  output logic [NUM_PINS-1:0] drv_hi,
  output logic [NUM_PINS-1:0] drv_lo,
  output logic [NUM_PINS-1:0] pull_up,
  output logic [NUM_PINS-1:0] in_en
);
  logic [NUM_PINS-1:0] hi_d, lo_d, pu_d;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic      bit_out;
    logic      h, l, p;
    drv_code_e code;
    assign bit_out = byp_q[i] ? periph[i] : data_q[i];
    assign code    = drv_code_e'({mode1_q[i], mode0_q[i]});
    always_comb begin
      h = 1'b0;
      l = 1'b0;
      p = 1'b0;
      if (!ana_q[i]) begin
        case (code)
          DRV_PULL_STRONG0: begin l = ~bit_out; p = bit_out; end
          DRV_PUSH_PULL:    begin h = bit_out;  l = ~bit_out; end
          DRV_OPEN_DRAIN:   l = ~bit_out;
          default: ;
        endcase
      end
    end
    assign hi_d[i] = h;
    assign lo_d[i] = l;
    assign pu_d[i] = p;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_hi  <= '0;
      drv_lo  <= '0;
      pull_up <= '0;
      in_en   <= '1;
    end else begin
      drv_hi  <= hi_d;
      drv_lo  <= lo_d;
      pull_up <= pu_d;
      in_en   <= ~ana_q;
    end
  end

  // R11
  no_contention_chk: assert property (@(posedge clk) disable iff (rst)
    (drv_hi & drv_lo) == '0);
  // R7
  analog_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((drv_hi | drv_lo | pull_up | in_en) & $past(ana_q)) == '0));
  // R8
  input_en_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((in_en | $past(ana_q)) == '1));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [NUM_PINS-1:0] reg_wdata,
  output logic [NUM_PINS-1:0] reg_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  input  logic [NUM_PINS-1:0] periph_out,
  output logic [NUM_PINS-1:0] pad_drv_hi,
  output logic [NUM_PINS-1:0] pad_drv_lo,
  output logic [NUM_PINS-1:0] pad_pull_up,
  output logic [NUM_PINS-1:0] pad_in_en
);
  logic [NUM_PINS-1:0] data_q, mode0_q, mode1_q, ana_q, byp_q, pad_sync;

  gpio_reg_bank #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .data_q(data_q), .mode0_q(mode0_q), .mode1_q(mode1_q),
    .ana_q(ana_q), .byp_q(byp_q)
  );

  gpio_pad_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pad(pad_in), .pad_sync(pad_sync)
  );

  gpio_drive_decode #(.NUM_PINS(NUM_PINS)) u_decode (
    .clk(clk), .rst(rst), .data_q(data_q), .mode0_q(mode0_q),
    .mode1_q(mode1_q), .ana_q(ana_q), .byp_q(byp_q), .periph(periph_out),
    .drv_hi(pad_drv_hi), .drv_lo(pad_drv_lo), .pull_up(pad_pull_up),
    .in_en(pad_in_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (int'(reg_addr))
        OFF_DATA:  reg_rdata <= pad_sync & ~ana_q;
        OFF_MODE0: reg_rdata <= mode0_q;
        OFF_MODE1: reg_rdata <= mode1_q;
        OFF_ANA:   reg_rdata <= ana_q;
        OFF_BYP:   reg_rdata <= byp_q;
        default:   reg_rdata <= '0;
      endcase
    end
  end

  // R7
  ana_read_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && int'(reg_addr) == OFF_DATA) |=> ((reg_rdata & $past(ana_q)) == '0));
endmodule

// File: tb/gpio_port_ctrl_bench.sv
module gpio_port_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [7:0] pad_in = 8'hA5, periph_out = '0;
  logic [7:0] pad_drv_hi, pad_drv_lo, pad_pull_up, pad_in_en;

  int checks = 0, errors = 0;
  logic [7:0] m_data = '0, m_m0 = '0, m_m1 = '1, m_ana = '0, m_byp = '0;

  gpio_port_ctrl u_gpio_port_ctrl (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .periph_out(periph_out), .pad_drv_hi(pad_drv_hi), .pad_drv_lo(pad_drv_lo),
    .pad_pull_up(pad_pull_up), .pad_in_en(pad_in_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [7:0] f_out();
    return (m_byp & periph_out) | (~m_byp & m_data);
  endfunction
  function automatic logic [7:0] f_hi();
    return ~m_ana & ~m_m1 & m_m0 & f_out();
  endfunction
  function automatic logic [7:0] f_lo();
    return ~m_ana & ~(m_m1 & ~m_m0) & ~f_out();
  endfunction
  function automatic logic [7:0] f_pu();
    return ~m_ana & ~m_m1 & ~m_m0 & f_out();
  endfunction
  function automatic logic [7:0] f_rd(input logic [2:0] a);
    case (a)
      3'd0: return pad_in & ~m_ana;
      3'd1: return m_m0;
      3'd2: return m_m1;
      3'd3: return m_ana;
      3'd4: return m_byp;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      3'd0: m_data = d;
      3'd1: m_m0 = d;
      3'd2: m_m1 = d;
      3'd3: m_ana = d;
      3'd4: m_byp = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] q);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    q = reg_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_pads(input string req);
    chk({req, " hi"}, pad_drv_hi, f_hi());
    chk({req, " lo"}, pad_drv_lo, f_lo());
    chk({req, " pu"}, pad_pull_up, f_pu());
    chk({req, " ie"}, pad_in_en, ~m_ana);
    chk("R11 contention", pad_drv_hi & pad_drv_lo, 8'h00);
  endtask

  task automatic chk_read(input string req, input logic [2:0] a);
    logic [7:0] q;
    rd(a, q);
    chk(req, q, f_rd(a));
  endtask

  initial begin
    logic [7:0] q;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 hi", pad_drv_hi, 8'h00);
    chk("R10 lo", pad_drv_lo, 8'h00);
    chk("R10 pu", pad_pull_up, 8'h00);
    chk("R10 ie", pad_in_en, 8'hFF);
    chk_read("R10 mode0", 3'd1);
    chk_read("R10 mode1", 3'd2);
    chk_read("R10 ana", 3'd3);
    chk_read("R10 byp", 3'd4);
    // R5 high-Z input with data set
    wr(3'd0, 8'h5A); settle(); chk_pads("R5");
    // R2 read returns pads, not latch
    pad_in = 8'h3C; settle();
    rd(3'd0, q); chk("R2 pad read", q, 8'h3C);
    // R1, R3 pull/strong0
    wr(3'd2, 8'h00); wr(3'd1, 8'h00); settle(); chk_pads("R1 R3");
    // R4 push-pull
    wr(3'd1, 8'hFF); settle(); chk_pads("R4");
    // R6 open drain
    wr(3'd2, 8'hFF); settle(); chk_pads("R6");
    // R9 bypass, push-pull
    wr(3'd2, 8'h00); wr(3'd4, 8'hF0); periph_out = 8'hC3; settle(); chk_pads("R9");
    periph_out = 8'h3C; settle(); chk_pads("R9 periph change");
    // R7 analog override
    wr(3'd3, 8'h81); settle(); chk_pads("R7 R8");
    pad_in = 8'hFF; settle();
    rd(3'd0, q); chk("R7 analog read", q, 8'h7E);
    // R12 readback and unmapped
    wr(3'd5, 8'hFF); wr(3'd6, 8'h12); wr(3'd7, 8'h34); settle();
    chk_read("R12 unmapped5", 3'd5);
    chk_read("R12 unmapped7", 3'd7);
    chk_read("R12 mode0", 3'd1);
    chk_read("R12 byp", 3'd4);
    chk_pads("R12 no effect");
    // R13 read-modify-write hazard
    wr(3'd3, 8'h00); wr(3'd4, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    wr(3'd0, 8'hFF); pad_in = 8'hF7; settle();
    rd(3'd0, q); chk("R13 read", q, 8'hF7);
    wr(3'd0, q & 8'h7F); pad_in = 8'hFF; settle();
    chk("R13 strong low", pad_drv_lo, 8'h88);
    chk("R13 pull up", pad_pull_up, 8'h77);
    // random mix
    for (int n = 0; n < 400; n++) begin
      pad_in = 8'($urandom); periph_out = 8'($urandom);
      wr(3'($urandom_range(0, 7)), 8'($urandom));
      settle();
      chk_pads("R1 R3 R4 R5 R6 R7 R9 random");
      chk_read("R2 R12 random read", 3'($urandom_range(0, 7)));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule